// File: doc/BRIEF.md
# DMA Channel Register Bank

This block holds the software-visible settings and status of one DMA channel. A processor reaches sixteen word-spaced slots through a small register bus, using 16-bit or 32-bit accesses. The slots hold the descriptor pointer, the start address, the channel configuration, the X and Y counts and their signed strides, and the working copies of the pointer, address and counts. They also hold the interrupt status word and the peripheral mapping word. The block does not move data itself. It tells a separate transfer engine when to start and stop, and takes back one-cycle completion and error reports from that engine.

The status word owns the channel's run flag. Writing the configuration slot with its enable bit set raises the flag, copies the programmed parameters into the working slots and pulses the start output. Writing it with enable clear drops the flag and pulses the stop output. While the flag is up, software cannot change the programmed parameters, the working copies or the peripheral mapping. Completion and error flags are cleared by writing ones to them. Malformed accesses produce a one-cycle bus error and leave every slot untouched.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every slot reads zero, except the peripheral mapping slot (slot 11), which reads the parameter PMAP_RESET.
- R2: The slot index is address bits [5:2]. Slots 0 (descriptor pointer), 1 (start address), 8 (working descriptor pointer) and 9 (working address) are 32 bits wide. Every other slot is 16 bits wide, and its upper half reads as zero.
- R3: busSize 2'b01 selects a 16-bit access and 2'b10 selects a 32-bit access. A 16-bit read returns the low half, zero-extended. A 16-bit write to a 32-bit slot changes only its low half.
- R4: While RUN (status bit 3) is set, writes to slots 0, 1, 4 to 9, 11, 12 and 14 are dropped without a bus error.
- R5: A configuration write (slot 2) with bit 0 set stores the value and sets RUN. It pulses startPulse for one cycle. It also loads slot 8 from slot 0, slot 9 from slot 1, slot 12 from slot 4 and slot 14 from slot 6, where a zero count loads as 16'hFFFF. The configuration slot stays writable while running.
- R6: A configuration write with bit 0 clear stores the value, clears RUN and pulses stopPulse for one cycle.
- R7: In the status slot (slot 10), writing 1 to bit 0 (DONE) or bit 1 (ERR) clears that bit, and writing 0 leaves it unchanged. No bus write can set any status bit.
- R8: An engDone pulse sets DONE and clears RUN. An engErr pulse sets ERR. An engine set in the same cycle as a clearing write leaves the bit set. A same-cycle start keeps RUN set.
- R9: A write to the peripheral mapping slot keeps bit TYPE_BIT and replaces only the other bits.
- R10: A bus error is reported one cycle after an access with size 2'b00 or 2'b11, a nonzero address [1:0], or a write to reserved slots 3, 13 or 15. Such an access changes nothing and returns no read data. A read of a reserved slot is legal and returns zero.
- R11: A legal read raises rdValid one cycle later, with the slot value as it stood before that cycle's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busSize | input | 2 | 01 = 16-bit, 10 = 32-bit, other values illegal |
| busAddr | input | ADDR_W | Byte offset inside the bank |
| busWdata | input | 32 | Write data |
| rdData | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | Read response, one cycle after the request |
| busErr | output | 1 | One-cycle illegal-access pulse |
| startPulse | output | 1 | Tells the engine to begin |
| stopPulse | output | 1 | Tells the engine to abandon work |
| engDone | input | 1 | Engine completion pulse |
| engErr | input | 1 | Engine error pulse |

## Verification
Two functions can meet in one cycle: an engine report setting DONE or ERR, and a software write-one-to-clear of that same bit. The bench provokes this deliberately, with a clearing status write issued alongside engErr or engDone. It also lets the random stream overlap engine pulses with status writes and configuration writes. The outcome is judged by reading the status slot afterwards: it must show the bit still set, and after a same-cycle start it must show RUN still held.

// File: rtl/dma_chan_regs_pkg.sv
package dma_chan_regs_pkg;

  localparam int SLOTS      = 16;
  localparam int SLOT_IDX_W = 4;

  localparam int SL_NEXT_DESC = 0;
  localparam int SL_START     = 1;
  localparam int SL_CFG       = 2;
  localparam int SL_XCNT      = 4;
  localparam int SL_YCNT      = 6;
  localparam int SL_CUR_DESC  = 8;
  localparam int SL_CUR_ADDR  = 9;
  localparam int SL_STATUS    = 10;
  localparam int SL_PMAP      = 11;
  localparam int SL_CUR_X     = 12;
  localparam int SL_CUR_Y     = 14;

  localparam int ST_DONE = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_RUN  = 3;
  localparam int CFG_EN  = 0;

  function automatic bit slotIsReserved(int i);
    return (i == 3) || (i == 13) || (i == 15);
  endfunction

  function automatic bit slotIsWide(int i);
    return (i == SL_NEXT_DESC) || (i == SL_START) || (i == SL_CUR_DESC) || (i == SL_CUR_ADDR);
  endfunction

  function automatic bit slotIsLoaded(int i);
    return (i == SL_CUR_DESC) || (i == SL_CUR_ADDR) || (i == SL_CUR_X) || (i == SL_CUR_Y);
  endfunction

  typedef struct packed {
    logic [SLOTS-1:0]      wrSel;
    logic                  full32;
    logic                  start;
    logic                  stop;
    logic                  w1c;
    logic                  rdEn;
    logic [SLOT_IDX_W-1:0] rdIdx;
    logic                  busErr;
  } strobe_t;

endpackage

// File: rtl/dma_chan_regs_ctrl.sv
module dma_chan_regs_ctrl
  import dma_chan_regs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              cfgEnBit,
  input  logic              isRunning,
  output strobe_t           stb
);

  localparam int IDX_LSB = 2;
  localparam int IDX_MSB = IDX_LSB + SLOT_IDX_W - 1;

  logic [SLOT_IDX_W-1:0] idx;
  logic sizeOk, alignOk, inRange, rsvWrite, legal, acc;

  assign idx      = busAddr[IDX_MSB:IDX_LSB];
  assign sizeOk   = (busSize == 2'b01) || (busSize == 2'b10);
  assign alignOk  = (busAddr[1:0] == 2'b00);
  assign inRange  = ((busAddr >> (IDX_MSB + 1)) == '0);
  assign rsvWrite = busWrite && slotIsReserved(int'(idx));
  assign legal    = sizeOk && alignOk && inRange && !rsvWrite;
  assign acc      = busValid && legal;

  always_comb begin
    stb        = '0;
    stb.busErr = busValid && !legal;
    stb.full32 = (busSize == 2'b10);
    stb.rdIdx  = idx;
    stb.rdEn   = acc && !busWrite;
    if (acc && busWrite) begin
      if (int'(idx) == SL_CFG) begin
        stb.wrSel[idx] = 1'b1;
        stb.start      = cfgEnBit;
        stb.stop       = !cfgEnBit;
      end else if (int'(idx) == SL_STATUS) begin
        stb.w1c = 1'b1;
      end else begin
        stb.wrSel[idx] = !isRunning;
      end
    end
  end

endmodule

// File: rtl/dma_chan_regs_dp.sv
module dma_chan_regs_dp
  import dma_chan_regs_pkg::*;
#(
  parameter logic [15:0] PMAP_RESET = 16'h0045,
  parameter int          TYPE_BIT   = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  strobe_t     stb,
  input  logic [31:0] busWdata,
  input  logic        engDone,
  input  logic        engErr,
  output logic [31:0] slotView [SLOTS],
  output logic        isRunning,
  output logic [31:0] rdData,
  output logic        rdValid,
  output logic        busErr,
  output logic        startPulse,
  output logic        stopPulse
);

  localparam logic [15:0] TYPE_MASK = 16'(1) << TYPE_BIT;

  logic [31:0] curXLd, curYLd;
  assign curXLd = (slotView[SL_XCNT][15:0] == '0) ? 32'h0000_FFFF : {16'b0, slotView[SL_XCNT][15:0]};
  assign curYLd = (slotView[SL_YCNT][15:0] == '0) ? 32'h0000_FFFF : {16'b0, slotView[SL_YCNT][15:0]};

  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    if (slotIsReserved(g)) begin : gRsv
      assign slotView[g] = '0;
    end else if (g == SL_STATUS) begin : gStat
      logic [15:0] q;
      logic doneN, errN, runN;
      always_comb begin
        doneN = (q[ST_DONE] && !(stb.w1c && busWdata[ST_DONE])) || engDone;
        errN  = (q[ST_ERR]  && !(stb.w1c && busWdata[ST_ERR]))  || engErr;
        if (stb.start)     runN = 1'b1;
        else if (stb.stop) runN = 1'b0;
        else if (engDone)  runN = 1'b0;
        else               runN = q[ST_RUN];
      end
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else begin
          q[ST_DONE] <= doneN;
          q[ST_ERR]  <= errN;
          q[ST_RUN]  <= runN;
        end
      end
      assign slotView[g] = {16'b0, q};
    end else if (g == SL_PMAP) begin : gPmap
      logic [15:0] q;
      always_ff @(posedge clk) begin
        if (rst)               q <= PMAP_RESET;
        else if (stb.wrSel[g]) q <= (busWdata[15:0] & ~TYPE_MASK) | (q & TYPE_MASK);
      end
      assign slotView[g] = {16'b0, q};
    end else begin : gGen
      localparam bit WIDE  = slotIsWide(g);
      localparam bit LOADS = slotIsLoaded(g);
      logic [31:0] q, merged, loadVal;
      assign loadVal = (g == SL_CUR_DESC) ? slotView[SL_NEXT_DESC] :
                       (g == SL_CUR_ADDR) ? slotView[SL_START] :
                       (g == SL_CUR_X)    ? curXLd : curYLd;
      always_comb begin
        if (stb.full32) merged = WIDE ? busWdata : {16'b0, busWdata[15:0]};
        else            merged = {(WIDE ? q[31:16] : 16'b0), busWdata[15:0]};
      end
      always_ff @(posedge clk) begin
        if (rst)                       q <= '0;
        else if (LOADS && stb.start)   q <= loadVal;
        else if (stb.wrSel[g])         q <= merged;
      end
      assign slotView[g] = q;
    end
  end

  assign isRunning = slotView[SL_STATUS][ST_RUN];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData     <= '0;
      rdValid    <= 1'b0;
      busErr     <= 1'b0;
      startPulse <= 1'b0;
      stopPulse  <= 1'b0;
    end else begin
      rdValid    <= stb.rdEn;
      busErr     <= stb.busErr;
      startPulse <= stb.start;
      stopPulse  <= stb.stop;
      if (stb.rdEn)
        rdData <= stb.full32 ? slotView[stb.rdIdx] : {16'b0, slotView[stb.rdIdx][15:0]};
      else
        rdData <= '0;
    end
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_regs_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter logic [15:0] PMAP_RESET = 16'h0045,
  parameter int          TYPE_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       rdData,
  output logic              rdValid,
  output logic              busErr,
  output logic              startPulse,
  output logic              stopPulse,
  input  logic              engDone,
  input  logic              engErr
);

  strobe_t     stb;
  logic [31:0] slotView [SLOTS];
  logic        isRunning;

  logic        statRun, statDone, pmapType;
  logic [31:0] startAddr;
  assign statRun   = slotView[SL_STATUS][ST_RUN];
  assign statDone  = slotView[SL_STATUS][ST_DONE];
  assign pmapType  = slotView[SL_PMAP][TYPE_BIT];
  assign startAddr = slotView[SL_START];

  dma_chan_regs_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busSize   (busSize),
    .busAddr   (busAddr),
    .cfgEnBit  (busWdata[CFG_EN]),
    .isRunning (isRunning),
    .stb       (stb)
  );

  dma_chan_regs_dp #(.PMAP_RESET(PMAP_RESET), .TYPE_BIT(TYPE_BIT)) i_dp (
    .clk        (clk),
    .rst        (rst),
    .stb        (stb),
    .busWdata   (busWdata),
    .engDone    (engDone),
    .engErr     (engErr),
    .slotView   (slotView),
    .isRunning  (isRunning),
    .rdData     (rdData),
    .rdValid    (rdValid),
    .busErr     (busErr),
    .startPulse (startPulse),
    .stopPulse  (stopPulse)
  );

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic        startPulse,
  input logic        stopPulse,
  input logic        rdValid,
  input logic        busErr,
  input logic        engDone,
  input logic        statRun,
  input logic        statDone,
  input logic        pmapType,
  input logic [31:0] startAddr
);

  p_run_locks_start_r4: assert property (@(posedge clk) disable iff (rst)
    statRun |=> $stable(startAddr));

  p_start_sets_run_r5: assert property (@(posedge clk) disable iff (rst)
    startPulse |-> statRun);

  p_stop_clears_run_r6: assert property (@(posedge clk) disable iff (rst)
    stopPulse |-> !statRun);

  p_start_stop_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(startPulse && stopPulse));

  p_done_sets_r8: assert property (@(posedge clk) disable iff (rst)
    engDone |=> statDone);

  p_type_kept_r9: assert property (@(posedge clk) disable iff (rst)
    $stable(pmapType));

  p_err_no_data_r10: assert property (@(posedge clk) disable iff (rst)
    busErr |-> !rdValid);

endmodule

bind dma_chan_regs dma_chan_regs_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .startPulse (startPulse),
  .stopPulse  (stopPulse),
  .rdValid    (rdValid),
  .busErr     (busErr),
  .engDone    (engDone),
  .statRun    (statRun),
  .statDone   (statDone),
  .pmapType   (pmapType),
  .startAddr  (startAddr)
);

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/100ps
module test_dma_chan_regs;

  localparam logic [15:0] PMAP_INIT = 16'h0045;
  localparam int          TYPE_POS  = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [1:0]  busSize = 2'b10;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        engDone = 1'b0, engErr = 1'b0;
  logic [31:0] rdData;
  logic        rdValid, busErr, startPulse, stopPulse;

  int checks = 0;
  int errors = 0;
  logic [31:0] m [16];

  always #2.5 clk = ~clk;

  dma_chan_regs #(.ADDR_W(6), .PMAP_RESET(PMAP_INIT), .TYPE_BIT(TYPE_POS)) i_dma_chan_regs (
    .clk(clk), .rst(rst), .busValid(busValid), .busWrite(busWrite), .busSize(busSize),
    .busAddr(busAddr), .busWdata(busWdata), .rdData(rdData), .rdValid(rdValid),
    .busErr(busErr), .startPulse(startPulse), .stopPulse(stopPulse),
    .engDone(engDone), .engErr(engErr)
  );

  function automatic bit isRsv(int i);
    return i == 3 || i == 13 || i == 15;
  endfunction

  function automatic bit isWide(int i);
    return i == 0 || i == 1 || i == 8 || i == 9;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doOp(string tag, bit v, bit w, bit [1:0] sz, bit [5:0] a,
                      bit [31:0] wd, bit ed, bit ee);
    int idx = int'(a[5:2]);
    bit legal = v && (sz == 2'b01 || sz == 2'b10) && a[1:0] == 2'b00 && !(w && isRsv(idx));
    bit running = m[10][3];
    bit st = legal && w && idx == 2 && wd[0];
    bit sp = legal && w && idx == 2 && !wd[0];
    bit w1c = legal && w && idx == 10;
    logic [31:0] expRd = (legal && !w) ? ((sz == 2'b10) ? m[idx] : {16'b0, m[idx][15:0]}) : '0;
    logic [31:0] nm [16];
    busValid = v; busWrite = w; busSize = sz; busAddr = a; busWdata = wd;
    engDone = ed; engErr = ee;
    @(posedge clk);
    @(negedge clk);
    busValid = 1'b0; engDone = 1'b0; engErr = 1'b0;
    chk({tag, " rdValid"}, 32'(rdValid), 32'(legal && !w));
    if (legal && !w) chk({tag, " rdData"}, rdData, expRd);
    chk({tag, " busErr"}, 32'(busErr), 32'(v && !legal));
    chk({tag, " startPulse"}, 32'(startPulse), 32'(st));
    chk({tag, " stopPulse"}, 32'(stopPulse), 32'(sp));
    nm = m;
    if (legal && w) begin
      if (idx == 2) begin
        nm[2] = {16'b0, wd[15:0]};
        if (st) begin
          nm[8]  = m[0];
          nm[9]  = m[1];
          nm[12] = (m[4][15:0] == 0) ? 32'hFFFF : {16'b0, m[4][15:0]};
          nm[14] = (m[6][15:0] == 0) ? 32'hFFFF : {16'b0, m[6][15:0]};
        end
      end else if (idx == 11) begin
        if (!running)
          nm[11] = {16'b0, (wd[15:0] & ~(16'(1) << TYPE_POS)) | (m[11][15:0] & (16'(1) << TYPE_POS))};
      end else if (idx != 10 && !running) begin
        if (sz == 2'b10) nm[idx] = isWide(idx) ? wd : {16'b0, wd[15:0]};
        else nm[idx] = {(isWide(idx) ? m[idx][31:16] : 16'b0), wd[15:0]};
      end
    end
    nm[10][0] = (m[10][0] && !(w1c && wd[0])) || ed;
    nm[10][1] = (m[10][1] && !(w1c && wd[1])) || ee;
    nm[10][3] = st ? 1'b1 : sp ? 1'b0 : ed ? 1'b0 : m[10][3];
    m = nm;
  endtask

  task automatic rd(string tag, int idx);
    doOp(tag, 1, 0, 2'b10, 6'(idx * 4), 0, 0, 0);
  endtask

  task automatic wr(string tag, int idx, bit [31:0] d);
    doOp(tag, 1, 1, 2'b10, 6'(idx * 4), d, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed = 32'h5eed;
    void'($urandom(seed));
    for (int i = 0; i < 16; i++) m[i] = '0;
    m[11] = {16'b0, PMAP_INIT};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 16; i++) rd("R1 reset", i);

    wr("R2 wide", 0, 32'hA5A5_1234);
    wr("R2 narrow", 4, 32'hA5A5_1234);
    rd("R2 wide", 0);
    rd("R2 narrow", 4);

    wr("R3", 1, 32'h1111_2222);
    doOp("R3 half write", 1, 1, 2'b01, 6'h04, 32'h9999_BEEF, 0, 0);
    rd("R3", 1);
    doOp("R3 half read", 1, 0, 2'b01, 6'h04, 0, 0, 0);

    wr("R5 xcnt", 4, 32'h0);
    wr("R5 ycnt", 6, 32'h5);
    wr("R5 start", 2, 32'h0000_0081);
    for (int i = 8; i <= 14; i++) rd("R5 load", i);

    wr("R4 locked", 1, 32'hDEAD_BEEF);
    wr("R4 locked", 11, 32'h0);
    wr("R4 locked", 12, 32'h7);
    rd("R4", 1);
    rd("R4", 11);
    rd("R4", 12);
    wr("R5 cfg while running", 2, 32'h0000_0003);
    rd("R5", 2);

    doOp("R8 done", 0, 0, 2'b10, 0, 0, 1, 0);
    rd("R8 status", 10);
    doOp("R7 write zero", 1, 1, 2'b10, 6'h28, 32'h0, 0, 0);
    rd("R7", 10);
    doOp("R8 err vs clear", 1, 1, 2'b10, 6'h28, 32'h3, 0, 1);
    rd("R8 set wins", 10);
    doOp("R7 clear", 1, 1, 2'b10, 6'h28, 32'hFFFF, 0, 0);
    rd("R7 cleared", 10);
    doOp("R8 start with done", 1, 1, 2'b10, 6'h08, 32'h1, 1, 0);
    rd("R8 run held", 10);

    wr("R6 stop", 2, 32'h0);
    rd("R6 status", 10);
    wr("R9 pmap", 11, 32'h0000_0000);
    rd("R9", 11);
    wr("R9 pmap", 11, 32'h0000_FFBF);
    rd("R9", 11);

    doOp("R10 size", 1, 1, 2'b00, 6'h04, 32'h1, 0, 0);
    doOp("R10 size", 1, 0, 2'b11, 6'h04, 32'h1, 0, 0);
    doOp("R10 align", 1, 1, 2'b10, 6'h05, 32'h1, 0, 0);
    doOp("R10 rsv write", 1, 1, 2'b10, 6'h0C, 32'h1, 0, 0);
    rd("R10 rsv read", 3);
    rd("R10 unchanged", 1);

    for (int n = 0; n < 4000; n++) begin
      bit v = ($urandom % 8) != 0;
      bit w = ($urandom % 2) == 1;
      bit [1:0] sz = (($urandom % 10) == 0) ? 2'($urandom) : ((($urandom % 2) == 1) ? 2'b10 : 2'b01);
      bit [5:0] a = {4'($urandom), ((($urandom % 10) == 0) ? 2'($urandom) : 2'b00)};
      bit [31:0] d = $urandom;
      bit ed = ($urandom % 16) == 0;
      bit ee = ($urandom % 16) == 0;
      string tag = "R11 random";
      if (v && w && a[5:2] == 4'd10) tag = "R7 random";
      else if (v && w && a[5:2] == 4'd2) tag = "R5 random";
      else if (v && w) tag = "R4 random";
      if (v && w && a[5:2] == 4'd4 && ($urandom % 3) == 0) d = 0;
      doOp(tag, v, w, sz, a, d, ed, ee);
    end
    for (int i = 0; i < 16; i++) rd("R11 final", i);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule